// File: doc/BRIEF.md
# Two-Slot Relay Station

This block is a clocked pipeline stage for a long point-to-point channel between two stallable units. Each cycle the upstream side presents a token, which is a data word with a valid flag; a token with the flag low is a void. The stage hands each accepted token to its output one clock later. It never makes a valid token of its own: it only passes on what it receives, and void tokens pass through as voids.

Storage is two slots. The main slot drives the output. The auxiliary slot catches the one token that arrives while the downstream side is stalling the stage. A registered stop line tells the upstream side to hold its current token whenever the auxiliary slot is occupied. While that stop line is high, any token presented is not taken, because the upstream side re-presents it later. When the downstream stall lifts, the stage sends out the main slot first and then the auxiliary slot. Order is kept and no token is lost or duplicated.

Top module: `relay_station`

## Requirements
- R1: In the first cycle after reset, `dn_valid` is 0 and `up_stop` is 0.
- R2: When the stage takes a token (`up_stop` low, and the main slot is free or being drained), that token appears on `dn_valid`/`dn_data` after exactly one rising clock edge.
- R3: Over any run, the number of valid tokens delivered downstream never exceeds the number accepted from upstream.
- R4: While `dn_valid` is 1 and `dn_stop` is 1, the output token stays unchanged at the next edge.
- R5: `up_stop` goes to 1 at the edge where a valid token arrives while the output holds a valid token under `dn_stop`. It stays 1 only while that extra token is stored. `up_stop` is never 1 while `dn_valid` is 0.
- R6: Under any pattern of `dn_stop` and of upstream gaps, the sequence of valid tokens delivered equals the sequence sent. Nothing is lost, duplicated or reordered.
- R7: A void input taken with no stall gives a void output one edge later.
- R8: A void output does not block the stage. While `dn_valid` is 0, an incoming token is taken even if `dn_stop` is 1.
- R9: When `dn_stop` drops with both slots full, the main token leaves at that edge and the stored token is on the output after it. `up_stop` returns to 0 at the same edge. A token presented while `up_stop` was 1 is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_valid | input | 1 | Incoming token is valid |
| up_data | input | W | Incoming token data |
| up_stop | output | 1 | Registered request that upstream hold its token |
| dn_valid | output | 1 | Outgoing token is valid |
| dn_data | output | W | Outgoing token data |
| dn_stop | input | 1 | Downstream stall request |

## Verification
Every result of this stage appears one rising edge after the stimulus that causes it. An accepted token reaches the output one edge later. `up_stop` rises one edge after the arrival that fills the auxiliary slot. After a release, the stored token reaches the output one edge later. The bench drives its inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. The random run logs each token at the falling edge before the rising edge that takes or delivers it, so both token lists follow the same edge accounting.

// File: rtl/relay_station.sv
module relay_station #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  input  logic [W-1:0] up_data,
  output logic         up_stop,
  output logic         dn_valid,
  output logic [W-1:0] dn_data,
  input  logic         dn_stop
);

  logic         main_v, aux_v;
  logic [W-1:0] main_d, aux_d;
  logic         drain;

  assign drain    = !dn_stop || !main_v;
  assign dn_valid = main_v;
  assign dn_data  = main_d;
  assign up_stop  = aux_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_v <= 1'b0;
      aux_v  <= 1'b0;
      main_d <= '0;
      aux_d  <= '0;
    end else if (drain) begin
      if (aux_v) begin
        main_v <= 1'b1;
        main_d <= aux_d;
        aux_v  <= 1'b0;
      end else begin
        main_v <= up_valid;
        main_d <= up_data;
      end
    end else if (!aux_v && up_valid) begin
      aux_v <= 1'b1;
      aux_d <= up_data;
    end
  end

endmodule

module relay_station_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         up_valid,
  input logic [W-1:0] up_data,
  input logic         up_stop,
  input logic         dn_valid,
  input logic [W-1:0] dn_data,
  input logic         dn_stop
);

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_stop && (!dn_stop || !dn_valid)) |=> (dn_valid && dn_data == $past(up_data)));

  assert_no_invent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_valid && !up_stop && (!dn_stop || !dn_valid)) |=> !dn_valid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_stop) |=> (dn_valid && $stable(dn_data)));

  assert_stop_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_stop && up_valid && !up_stop) |=> up_stop);

  assert_stop_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up_stop |-> dn_valid);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_stop && !dn_stop) |=> (dn_valid && !up_stop));

endmodule

bind relay_station relay_station_chk #(.W(W)) u_chk (.*);

// File: tb/sim_relay_station.sv
module sim_relay_station;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int NTOK = 300;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         up_valid = 1'b0, dn_stop = 1'b0;
  logic [W-1:0] up_data = '0;
  logic         up_stop, dn_valid;
  logic [W-1:0] dn_data;

  int checks = 0, failures = 0;
  logic [W-1:0] sent [NTOK];
  logic [W-1:0] got  [NTOK];
  int nsent, ngot;

  relay_station #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data),
    .up_stop(up_stop), .dn_valid(dn_valid), .dn_data(dn_data), .dn_stop(dn_stop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; up_valid = 1'b0; dn_stop = 1'b0; up_data = '0;
    step();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 dn_valid", {1'b0, W'(dn_valid)}, '0);
    check("R1 up_stop", {1'b0, W'(up_stop)}, '0);
  endtask

  task automatic t_pass();
    do_reset();
    up_valid = 1'b1; up_data = 16'h1234;
    step();
    check("R2 pass", {dn_valid, dn_data}, {1'b1, 16'h1234});
    up_valid = 1'b0; up_data = 16'hBEEF;
    step();
    check("R7 void", {1'b0, W'(dn_valid)}, '0);
  endtask

  task automatic t_hold();
    do_reset();
    up_valid = 1'b1; up_data = 16'h00A1;
    step();
    dn_stop = 1'b1; up_data = 16'h00B2;
    step();
    check("R4 hold", {dn_valid, dn_data}, {1'b1, 16'h00A1});
    check("R5 stop up", {1'b0, W'(up_stop)}, 17'h1);
    up_data = 16'h00C3;
    step();
    check("R4 hold2", {dn_valid, dn_data}, {1'b1, 16'h00A1});
    check("R5 stop kept", {1'b0, W'(up_stop)}, 17'h1);
    dn_stop = 1'b0; up_valid = 1'b0;
    step();
    check("R9 aux out", {dn_valid, dn_data}, {1'b1, 16'h00B2});
    check("R9 stop low", {1'b0, W'(up_stop)}, '0);
    step();
    check("R9 no extra", {1'b0, W'(dn_valid)}, '0);
  endtask

  task automatic t_void_stall();
    do_reset();
    dn_stop = 1'b1; up_valid = 1'b1; up_data = 16'h0D0D;
    step();
    check("R8 taken", {dn_valid, dn_data}, {1'b1, 16'h0D0D});
    check("R8 no stop", {1'b0, W'(up_stop)}, '0);
    up_valid = 1'b0; dn_stop = 1'b0;
    step();
  endtask

  task automatic t_random();
    int idx;
    bit pend;
    do_reset();
    nsent = 0; ngot = 0; idx = 0; pend = 1'b0;
    for (int cyc = 0; cyc < 5000 && ngot < NTOK; cyc++) begin
      if (pend) idx++;
      dn_stop = ($urandom_range(0, 99) < 40);
      if (idx < NTOK && $urandom_range(0, 3) != 0) begin
        up_valid = 1'b1; up_data = W'(idx * 37 + 5);
      end else begin
        up_valid = 1'b0; up_data = W'($urandom);
      end
      pend = up_valid && !up_stop;
      if (pend) begin sent[nsent] = up_data; nsent++; end
      if (dn_valid && !dn_stop) begin
        if (ngot < NTOK) got[ngot] = dn_data;
        ngot++;
      end
      step();
    end
    dn_stop = 1'b0; up_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (dn_valid) begin
        if (ngot < NTOK) got[ngot] = dn_data;
        ngot++;
      end
      step();
    end
    check("R3 count", 17'(ngot), 17'(nsent));
    check("R6 count", 17'(nsent), 17'(NTOK));
    for (int k = 0; k < NTOK; k++)
      if (k < ngot && got[k] !== sent[k]) begin
        check("R6 order", {1'b0, got[k]}, {1'b0, sent[k]});
        break;
      end
    checks++;
  endtask

  initial begin
    t_reset();
    t_pass();
    t_hold();
    t_void_stall();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end
endmodule